// File: doc/BRIEF.md
# Registered DIMM Mode-Register Write Sequencer

This block accepts one mode-register write request at a time and expands it into an ordered stream of commands for a downstream command-issue port. A registered DIMM needs two adjustments while a mode register is written: its command timing must be relaxed from one clock to three, and its address inversion must be switched off. The block therefore brackets the mode-register write with control-word writes that apply these adjustments before the write and undo them afterwards.

Each adjustment pair can be turned off on its own through a configuration input. This serves DIMMs whose register buffer makes the adjustment by itself. When the channel holds unbuffered DIMMs, no wrapping is done and only the bare mode-register write goes out. A programmable minimum spacing is kept between issued commands. The command port may stall at any time, and the block never drops or reorders commands. A one-cycle done pulse marks the end of each request.

Top module: `rdimm_mrs_wrapper`

## Requirements
- R1: With `cfg_registered` low, a request issues exactly one command: a mode-register write (`cmd_is_ctl`=0) that carries the request's rank, address and data. This holds whatever the skip inputs are.
- R2: With `cfg_registered` high and both skip inputs low, five commands are issued in this order, all on the request's rank: control word 2 with data 1 (3T timing); control word 0 with data 1 (inversion off); the mode-register write; control word 0 with data 0 (inversion on); control word 2 with data 0 (1T timing). A control-word write has `cmd_is_ctl`=1, the word number on `cmd_addr` and the value on `cmd_data`.
- R3: With `cfg_skip_timing` high, both control-word-2 writes are left out, and the rest of the order is unchanged.
- R4: With `cfg_skip_invert` high, both control-word-0 writes are left out, and the rest of the order is unchanged.
- R5: The configuration inputs are sampled only in the cycle a request is accepted. Changing them while a sequence is running has no effect on that sequence.
- R6: After a command handshake, `cmd_valid` stays low for exactly `cfg_gap` cycles before the next command is offered, provided one is pending.
- R7: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid` stays high and every command field holds its value.
- R8: `done` is high for one cycle, in the cycle after the final command handshake. `req_ready` is low from the cycle after acceptance until the cycle after `done`.
- R9: During reset and directly after it, `req_ready` is high and both `cmd_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_registered | input | 1 | Channel holds registered DIMMs |
| cfg_skip_timing | input | 1 | Leave out the 3T/1T control-word-2 writes |
| cfg_skip_invert | input | 1 | Leave out the inversion control-word-0 writes |
| cfg_gap | input | GAP_W | Idle cycles required between commands |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can accept a request |
| req_rank | input | RANK_W | Target rank |
| req_addr | input | ADDR_W | Mode register number |
| req_data | input | DATA_W | Mode register value |
| cmd_valid | output | 1 | Command offered |
| cmd_ready | input | 1 | Command port takes the command |
| cmd_is_ctl | output | 1 | 1 for a control-word write, 0 for a mode-register write |
| cmd_rank | output | RANK_W | Command rank |
| cmd_addr | output | ADDR_W | Control word number, or mode register number |
| cmd_data | output | DATA_W | Command data |
| done | output | 1 | One-cycle pulse when a request completes |

## Verification
The assertions assume that the configuration inputs are only required to be meaningful in the cycle a request is accepted. They also assume that `cfg_gap` does not change between a handshake and the cycle after it. The bench changes `cfg_gap` only while the block is idle, and it changes the configuration in the middle of a sequence only to exercise R5. It also assumes that `cmd_ready` may drop at any time. The bench drives it from a seeded random source with a small delay after each clock edge, so that stalls fall at every step of the sequence.

// File: rtl/rdimm_mrs_pkg.sv
package rdimm_mrs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } seq_state_e;

    // Step slots, lowest index issued first
    localparam int NUM_STEPS       = 5;
    localparam int STEP_W          = $clog2(NUM_STEPS);
    localparam int STEP_TIMING_ON  = 0;
    localparam int STEP_INV_OFF    = 1;
    localparam int STEP_MRS        = 2;
    localparam int STEP_INV_ON     = 3;
    localparam int STEP_TIMING_OFF = 4;

    localparam int CTL_TIMING_WORD = 2;
    localparam int CTL_INVERT_WORD = 0;
endpackage

// File: rtl/rdimm_step_plan.sv
module rdimm_step_plan
    import rdimm_mrs_pkg::*;
(
    input  logic                 registered,
    input  logic                 skip_timing,
    input  logic                 skip_invert,
    output logic [NUM_STEPS-1:0] mask
);
    logic use_timing;
    logic use_invert;

    always_comb begin
        use_timing = registered && !skip_timing;
        use_invert = registered && !skip_invert;
        mask = '0;
        mask[STEP_TIMING_ON]  = use_timing;
        mask[STEP_INV_OFF]    = use_invert;
        mask[STEP_MRS]        = 1'b1;
        mask[STEP_INV_ON]     = use_invert;
        mask[STEP_TIMING_OFF] = use_timing;
    end
endmodule

// File: rtl/rdimm_step_pick.sv
module rdimm_step_pick
    import rdimm_mrs_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16
) (
    input  logic [NUM_STEPS-1:0] pend,
    input  logic [ADDR_W-1:0]    mrs_addr,
    input  logic [DATA_W-1:0]    mrs_data,
    output logic                 any,
    output logic                 last,
    output logic [NUM_STEPS-1:0] sel,
    output logic                 is_ctl,
    output logic [ADDR_W-1:0]    addr,
    output logic [DATA_W-1:0]    data
);
    logic [STEP_W-1:0] pick;

    always_comb begin
        pick = STEP_W'(STEP_MRS);
        for (int i = NUM_STEPS - 1; i >= 0; i--) begin
            if (pend[i]) begin
                pick = STEP_W'(i);
            end
        end
        any  = |pend;
        sel  = '0;
        sel[pick] = any;
        last = ((pend & ~sel) == '0);

        is_ctl = 1'b1;
        addr   = ADDR_W'(CTL_TIMING_WORD);
        data   = '0;
        case (int'(pick))
            STEP_TIMING_ON: begin
                data = DATA_W'(1);
            end
            STEP_INV_OFF: begin
                addr = ADDR_W'(CTL_INVERT_WORD);
                data = DATA_W'(1);
            end
            STEP_MRS: begin
                is_ctl = 1'b0;
                addr   = mrs_addr;
                data   = mrs_data;
            end
            STEP_INV_ON: begin
                addr = ADDR_W'(CTL_INVERT_WORD);
            end
            default: begin
                addr = ADDR_W'(CTL_TIMING_WORD);
            end
        endcase
    end
endmodule

// File: rtl/rdimm_gap_timer.sv
module rdimm_gap_timer #(
    parameter int GAP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  logic [GAP_W-1:0] gap,
    output logic             open
);
    logic [GAP_W-1:0] cnt_d;
    logic [GAP_W-1:0] cnt_q;

    always_comb begin
        if (fire) begin
            cnt_d = gap;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end else begin
            cnt_d = cnt_q;
        end
        open = (cnt_q == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/rdimm_mrs_wrapper.sv
module rdimm_mrs_wrapper
    import rdimm_mrs_pkg::*;
#(
    parameter int RANK_W = 3,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16,
    parameter int GAP_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_registered,
    input  logic              cfg_skip_timing,
    input  logic              cfg_skip_invert,
    input  logic [GAP_W-1:0]  cfg_gap,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [RANK_W-1:0] req_rank,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic              cmd_is_ctl,
    output logic [RANK_W-1:0] cmd_rank,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DATA_W-1:0] cmd_data,
    output logic              done
);
    typedef struct packed {
        seq_state_e           state;
        logic [NUM_STEPS-1:0] pend;
        logic [RANK_W-1:0]    rank;
        logic [ADDR_W-1:0]    addr;
        logic [DATA_W-1:0]    data;
    } seq_regs_t;

    seq_regs_t            seq_d;
    seq_regs_t            seq_q;
    logic [NUM_STEPS-1:0] plan_mask;
    logic [NUM_STEPS-1:0] pick_sel;
    logic                 pick_any;
    logic                 pick_last;
    logic                 gap_open;
    logic                 issue;
    logic                 accept;

    rdimm_step_plan u_plan (
        .registered  (cfg_registered),
        .skip_timing (cfg_skip_timing),
        .skip_invert (cfg_skip_invert),
        .mask        (plan_mask)
    );

    rdimm_step_pick #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_pick (
        .pend     (seq_q.pend),
        .mrs_addr (seq_q.addr),
        .mrs_data (seq_q.data),
        .any      (pick_any),
        .last     (pick_last),
        .sel      (pick_sel),
        .is_ctl   (cmd_is_ctl),
        .addr     (cmd_addr),
        .data     (cmd_data)
    );

    rdimm_gap_timer #(
        .GAP_W (GAP_W)
    ) u_gap (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (issue),
        .gap   (cfg_gap),
        .open  (gap_open)
    );

    always_comb begin
        seq_d     = seq_q;
        req_ready = (seq_q.state == ST_IDLE);
        accept    = req_valid && req_ready;
        cmd_valid = (seq_q.state == ST_RUN) && gap_open && pick_any;
        issue     = cmd_valid && cmd_ready;
        cmd_rank  = seq_q.rank;
        done      = (seq_q.state == ST_FIN);

        case (seq_q.state)
            ST_IDLE: begin
                if (accept) begin
                    seq_d.state = ST_RUN;
                    seq_d.pend  = plan_mask;
                    seq_d.rank  = req_rank;
                    seq_d.addr  = req_addr;
                    seq_d.data  = req_data;
                end
            end
            ST_RUN: begin
                if (issue) begin
                    seq_d.pend = seq_q.pend & ~pick_sel;
                    if (pick_last) begin
                        seq_d.state = ST_FIN;
                    end
                end
            end
            default: begin
                seq_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{state: ST_IDLE, default: '0};
        end else begin
            seq_q <= seq_d;
        end
    end
endmodule

// File: rtl/rdimm_mrs_wrapper_chk.sv
module rdimm_mrs_wrapper_chk #(
    parameter int RANK_W = 3,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16,
    parameter int GAP_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_registered,
    input logic [GAP_W-1:0]  cfg_gap,
    input logic              req_valid,
    input logic              req_ready,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic              cmd_is_ctl,
    input logic [RANK_W-1:0] cmd_rank,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic [DATA_W-1:0] cmd_data,
    input logic              done
);
    logic busy_q;
    logic bare_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            bare_q <= 1'b0;
        end else if (req_valid && req_ready) begin
            busy_q <= 1'b1;
            bare_q <= !cfg_registered;
        end else if (done) begin
            busy_q <= 1'b0;
            bare_q <= 1'b0;
        end
    end

    // R1
    bare_only_mrs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && bare_q) |-> !cmd_is_ctl);

    // R2
    ctl_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_is_ctl) |->
            ((cmd_addr == ADDR_W'(2)) || (cmd_addr == ADDR_W'(0))) && (cmd_data <= DATA_W'(1)));

    // R6
    gap_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cfg_gap != '0) |=> !cmd_valid);

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> cmd_valid && $stable(cmd_is_ctl) && $stable(cmd_rank)
            && $stable(cmd_addr) && $stable(cmd_data));

    // R8
    done_after_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(cmd_valid && cmd_ready));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && req_ready);

    // R8
    no_accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> !req_ready);

    // R9
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |-> (!cmd_valid && !done && req_ready));
endmodule

bind rdimm_mrs_wrapper rdimm_mrs_wrapper_chk #(
    .RANK_W (RANK_W),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .GAP_W  (GAP_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_registered (cfg_registered),
    .cfg_gap        (cfg_gap),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .cmd_valid      (cmd_valid),
    .cmd_ready      (cmd_ready),
    .cmd_is_ctl     (cmd_is_ctl),
    .cmd_rank       (cmd_rank),
    .cmd_addr       (cmd_addr),
    .cmd_data       (cmd_data),
    .done           (done)
);

// File: tb/rdimm_mrs_wrapper_tb.sv
module rdimm_mrs_wrapper_tb;
    localparam int RANK_W = 3;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 16;
    localparam int GAP_W  = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_registered = 1'b0;
    logic              cfg_skip_timing = 1'b0;
    logic              cfg_skip_invert = 1'b0;
    logic [GAP_W-1:0]  cfg_gap = '0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [RANK_W-1:0] req_rank = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_data = '0;
    logic              cmd_valid;
    logic              cmd_ready = 1'b1;
    logic              cmd_is_ctl;
    logic [RANK_W-1:0] cmd_rank;
    logic [ADDR_W-1:0] cmd_addr;
    logic [DATA_W-1:0] cmd_data;
    logic              done;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit rand_ready = 1'b0;

    logic              rec_ctl  [8];
    logic [RANK_W-1:0] rec_rank [8];
    logic [ADDR_W-1:0] rec_addr [8];
    logic [DATA_W-1:0] rec_data [8];
    int                rec_cyc  [8];
    int                n_rec = 0;

    logic              exp_ctl  [5];
    logic [ADDR_W-1:0] exp_addr [5];
    logic [DATA_W-1:0] exp_data [5];
    int                n_exp = 0;

    logic              pv_hold = 1'b0;
    logic              pv_ctl;
    logic [RANK_W-1:0] pv_rank;
    logic [ADDR_W-1:0] pv_addr;
    logic [DATA_W-1:0] pv_data;

    rdimm_mrs_wrapper #(
        .RANK_W (RANK_W),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .GAP_W  (GAP_W)
    ) u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .cfg_registered  (cfg_registered),
        .cfg_skip_timing (cfg_skip_timing),
        .cfg_skip_invert (cfg_skip_invert),
        .cfg_gap         (cfg_gap),
        .req_valid       (req_valid),
        .req_ready       (req_ready),
        .req_rank        (req_rank),
        .req_addr        (req_addr),
        .req_data        (req_data),
        .cmd_valid       (cmd_valid),
        .cmd_ready       (cmd_ready),
        .cmd_is_ctl      (cmd_is_ctl),
        .cmd_rank        (cmd_rank),
        .cmd_addr        (cmd_addr),
        .cmd_data        (cmd_data),
        .done            (done)
    );

    always #2 clk = ~clk;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst_n && cmd_valid && cmd_ready) begin
            if (n_rec < 8) begin
                rec_ctl[n_rec]  <= cmd_is_ctl;
                rec_rank[n_rec] <= cmd_rank;
                rec_addr[n_rec] <= cmd_addr;
                rec_data[n_rec] <= cmd_data;
                rec_cyc[n_rec]  <= cyc;
            end
            n_rec <= n_rec + 1;
        end
        if (cyc > 100000) begin
            check(1'b0, "R8", "watchdog cycle", cyc, 100000);
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    always @(posedge clk) begin
        #1 cmd_ready = rand_ready ? (($urandom % 3) != 0) : 1'b1;
    end

    // R7: bench-side stall observation
    always @(negedge clk) begin
        if (rst_n) begin
            if (pv_hold) begin
                check(cmd_valid && cmd_is_ctl == pv_ctl && cmd_rank == pv_rank
                      && cmd_addr == pv_addr && cmd_data == pv_data,
                      "R7", "held command", int'(cmd_addr), int'(pv_addr));
            end
            pv_hold <= cmd_valid && !cmd_ready;
            pv_ctl  <= cmd_is_ctl;
            pv_rank <= cmd_rank;
            pv_addr <= cmd_addr;
            pv_data <= cmd_data;
        end
    end

    task automatic add_exp(input logic c, input int a, input logic [DATA_W-1:0] d);
        exp_ctl[n_exp]  = c;
        exp_addr[n_exp] = ADDR_W'(a);
        exp_data[n_exp] = d;
        n_exp++;
    endtask

    task automatic build_exp(input bit rg, input bit s3, input bit si,
                             input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        n_exp = 0;
        if (rg && !s3) add_exp(1'b1, 2, DATA_W'(1));
        if (rg && !si) add_exp(1'b1, 0, DATA_W'(1));
        add_exp(1'b0, int'(a), d);
        if (rg && !si) add_exp(1'b1, 0, DATA_W'(0));
        if (rg && !s3) add_exp(1'b1, 2, DATA_W'(0));
    endtask

    task automatic run_req(input string tag, input bit rg, input bit s3, input bit si,
                           input int gap, input logic [RANK_W-1:0] rk,
                           input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                           input bit flip);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        n_rec = 0;
        cfg_registered  = rg;
        cfg_skip_timing = s3;
        cfg_skip_invert = si;
        cfg_gap         = GAP_W'(gap);
        req_rank = rk;
        req_addr = a;
        req_data = d;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (flip) begin
            cfg_registered  = !rg;
            cfg_skip_timing = !s3;
            cfg_skip_invert = !si;
        end
        build_exp(rg, s3, si, a, d);
        while (!done) begin
            check(!req_ready, "R8", "req_ready while busy", int'(req_ready), 0);
            @(negedge clk);
        end
        check(n_rec == n_exp, tag, "command count", n_rec, n_exp);
        if (n_rec > 0 && n_rec <= 8) begin
            check(cyc == rec_cyc[n_rec-1] + 1, "R8", "done cycle", cyc, rec_cyc[n_rec-1] + 1);
        end
        for (int i = 0; i < n_exp && i < n_rec; i++) begin
            check(rec_ctl[i] == exp_ctl[i], tag, "is_ctl", int'(rec_ctl[i]), int'(exp_ctl[i]));
            check(rec_addr[i] == exp_addr[i], tag, "addr", int'(rec_addr[i]), int'(exp_addr[i]));
            check(rec_data[i] == exp_data[i], tag, "data", int'(rec_data[i]), int'(exp_data[i]));
            check(rec_rank[i] == rk, tag, "rank", int'(rec_rank[i]), int'(rk));
            if (i > 0) begin
                if (rand_ready) begin
                    check(rec_cyc[i] - rec_cyc[i-1] >= gap + 1, "R6", "min spacing",
                          rec_cyc[i] - rec_cyc[i-1], gap + 1);
                end else begin
                    check(rec_cyc[i] - rec_cyc[i-1] == gap + 1, "R6", "spacing",
                          rec_cyc[i] - rec_cyc[i-1], gap + 1);
                end
            end
        end
        @(negedge clk);
        check(!done, "R8", "done width", int'(done), 0);
        check(req_ready, "R8", "ready after done", int'(req_ready), 1);
    endtask

    initial begin
        process::self().srandom(32'd1234);
        repeat (3) begin
            @(negedge clk);
            // R9
            check(req_ready && !cmd_valid && !done, "R9", "reset outputs",
                  int'({req_ready, cmd_valid, done}), 4);
        end
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && !cmd_valid && !done, "R9", "after reset",
              int'({req_ready, cmd_valid, done}), 4);

        run_req("R1", 1'b0, 1'b0, 1'b0, 0, 3'd2, 4'd1, 16'h1234, 1'b0);
        run_req("R1", 1'b0, 1'b1, 1'b1, 1, 3'd5, 4'd3, 16'h00ff, 1'b0);
        run_req("R2", 1'b1, 1'b0, 1'b0, 0, 3'd1, 4'd2, 16'hbeef, 1'b0);
        run_req("R3", 1'b1, 1'b1, 1'b0, 0, 3'd6, 4'd0, 16'h0a0a, 1'b0);
        run_req("R4", 1'b1, 1'b0, 1'b1, 2, 3'd7, 4'd6, 16'h5555, 1'b0);
        run_req("R3", 1'b1, 1'b1, 1'b1, 0, 3'd0, 4'd5, 16'h7001, 1'b0);
        run_req("R6", 1'b1, 1'b0, 1'b0, 3, 3'd4, 4'd1, 16'h0042, 1'b0);
        run_req("R6", 1'b1, 1'b0, 1'b0, 15, 3'd3, 4'd7, 16'hffff, 1'b0);
        run_req("R5", 1'b1, 1'b0, 1'b0, 1, 3'd2, 4'd4, 16'hc0de, 1'b1);
        run_req("R5", 1'b0, 1'b1, 1'b1, 0, 3'd1, 4'd2, 16'h0001, 1'b1);

        rand_ready = 1'b1;
        run_req("R7", 1'b1, 1'b0, 1'b0, 0, 3'd5, 4'd3, 16'h3c3c, 1'b0);
        for (int n = 0; n < 40; n++) begin
            run_req("R2", 1'b1 ^ (($urandom % 4) == 0), 1'(($urandom % 3) == 0),
                    1'(($urandom % 3) == 0), int'($urandom % 4), RANK_W'($urandom),
                    ADDR_W'($urandom), DATA_W'($urandom), 1'(($urandom % 5) == 0));
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule